// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block collects a parameterised number of interrupt inputs (77 by default) and drives a single registered interrupt line toward a processor. Every input passes through a two-flop synchroniser. Each source has its own trigger type, priority, vector and enable. Software reaches these settings indirectly. It first writes a source index to a select register. Later mode, vector, enable, disable and clear accesses then apply to that source only.

Software handles an interrupt by reading the acknowledge register. The read returns the vector of the winning source and pushes that source's priority onto an internal stack, which is eight entries deep. Writing the end-of-interrupt register pops one entry. Only a source whose priority is strictly above the top of the stack can interrupt, so handlers nest by priority.

Sources flagged in the `EXT_MASK` parameter are external. Only external sources may use the inverted trigger types (falling edge, low level). A keyed write-protect register can lock the mode and vector settings.

Top module: `nested_prio_intc`

## Requirements
- R1: After reset the interrupt output is low, every source is disabled with mode 0 (high level, priority 0) and vector 0, the stack is empty, and the spurious vector is 0, so an acknowledge read returns 0.
- R2: Writes to address 0 with a value below NSRC select a source. Values of NSRC or more are ignored. Mode (addr 1), vector (addr 2), enable (addr 6), disable (addr 7) and clear (addr 8) accesses act on the selected source only. Reading address 0 returns the current selection.
- R3: The mode register holds the priority in bits [2:0] and the trigger in bits [5:4]: 00 high level, 01 rising edge, 10 low level, 11 falling edge. A mode write whose bit 5 is set is dropped entirely when the selected source is internal.
- R4: A level-triggered source requests for as long as its synchronised input is at the active level (1 for high level, 0 for low level).
- R5: An edge-triggered source latches a pending flag on the selected edge. The flag stays set after the input returns and is cleared by acknowledging that source or by the clear command.
- R6: Among enabled, requesting sources the highest priority wins, and a tie goes to the lowest source number. An acknowledge read (addr 3) returns the winner's vector.
- R7: A source interrupts only if no level is active or its priority is strictly above the top of the stack. An acknowledge read of such a source pushes its priority. Otherwise the read returns the spurious vector (addr 4) and pushes nothing.
- R8: Any write to address 5 pops one stack level, whatever the data. On an empty stack it has no effect.
- R9: Writing address 9 with bits [31:8] equal to 0x50524F sets write protection to bit 0. Any other key is ignored. While protection is on, mode and vector writes are ignored. Address 9 reads back the protection bit.
- R10: A disabled source never raises the interrupt output or wins an acknowledge. Enabling it lets a held request through.
- R11: The stack holds at most eight entries, and its entries increase strictly from bottom to top.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | NSRC | Raw interrupt inputs |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe; a read of address 3 acknowledges |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_re |
| irq | output | 1 | Registered interrupt request to the processor |

## Verification
The assertions assume that the bus carries at most one access per cycle, so a push and a pop never fall in the same cycle, and that source inputs stay stable for more than one clock. Given those inputs, they expect the stack to stay bounded and strictly ordered. The bench drives a single strobe per task call. It holds every input change for at least two cycles and waits past the synchroniser and output register before it samples. It sweeps every source alone, every pair of sources, and a full eight-level nesting on a 12-source instance.

// File: rtl/nested_prio_intc.sv
module nested_prio_intc #(
  parameter int NSRC = 77,
  parameter int NPRIO = 8,
  parameter int VEC_W = 8,
  parameter logic [NSRC-1:0] EXT_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [3:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  input  logic            bus_we,
  input  logic            bus_re,
  output logic [31:0]     bus_rdata,
  output logic            irq
);
  localparam int SW = $clog2(NSRC);
  localparam int PW = $clog2(NPRIO);
  localparam int DEPTH = NPRIO;
  localparam int SPW = $clog2(DEPTH + 1);
  localparam logic [23:0] WP_KEY = 24'h50524F;

  logic [NSRC-1:0] s1, s2, s3, en, epend, req;
  logic [1:0]       trig [NSRC];
  logic [PW-1:0]    prio [NSRC];
  logic [VEC_W-1:0] vec  [NSRC];
  logic [SW-1:0]    sel;
  logic [VEC_W-1:0] spur;
  logic             wp;
  logic [PW-1:0]    stk [DEPTH];
  logic [SPW-1:0]   sp;
  logic             best_ok, elig, irq_q;
  logic [PW-1:0]    best_p, top;
  logic [SW-1:0]    best_i;

  wire wr_sel  = bus_we && bus_addr == 4'd0;
  wire wr_mode = bus_we && bus_addr == 4'd1;
  wire wr_vec  = bus_we && bus_addr == 4'd2;
  wire wr_spur = bus_we && bus_addr == 4'd4;
  wire wr_eoi  = bus_we && bus_addr == 4'd5;
  wire wr_en   = bus_we && bus_addr == 4'd6;
  wire wr_dis  = bus_we && bus_addr == 4'd7;
  wire wr_clr  = bus_we && bus_addr == 4'd8;
  wire wr_wp   = bus_we && bus_addr == 4'd9;
  wire mode_ok = !wp && (!bus_wdata[5] || EXT_MASK[sel]);
  wire ack     = bus_re && bus_addr == 4'd3 && elig;
  wire [5:0] mode_sel = {trig[sel], 1'b0, PW'(prio[sel])};

  assign top  = (sp == '0) ? '0 : stk[PW'(sp - 1'b1)];
  assign elig = best_ok && (sp == '0 || best_p > top);
  assign irq  = irq_q;

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      req[i] = en[i] && (trig[i][0] ? epend[i] : (s2[i] ^ trig[i][1]));
  end

  always_comb begin
    best_ok = 1'b0;
    best_p = '0;
    best_i = '0;
    for (int i = 0; i < NSRC; i++)
      if (req[i] && (!best_ok || prio[i] > best_p)) begin
        best_ok = 1'b1;
        best_p = prio[i];
        best_i = SW'(i);
      end
  end

  always_comb begin
    case (bus_addr)
      4'd0: bus_rdata = 32'(sel);
      4'd1: bus_rdata = 32'(mode_sel);
      4'd2: bus_rdata = 32'(vec[sel]);
      4'd3: bus_rdata = elig ? 32'(vec[best_i]) : 32'(spur);
      4'd4: bus_rdata = 32'(spur);
      4'd9: bus_rdata = 32'(wp);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
      en <= '0; epend <= '0;
      sel <= '0; spur <= '0; wp <= 1'b0; irq_q <= 1'b0;
      for (int i = 0; i < NSRC; i++) begin
        trig[i] <= 2'b00; prio[i] <= '0; vec[i] <= '0;
      end
    end else begin
      s1 <= src_in; s2 <= s1; s3 <= s2;
      irq_q <= elig;
      if (wr_sel && bus_wdata < 32'(NSRC)) sel <= bus_wdata[SW-1:0];
      if (wr_spur) spur <= bus_wdata[VEC_W-1:0];
      if (wr_wp && bus_wdata[31:8] == WP_KEY) wp <= bus_wdata[0];
      for (int i = 0; i < NSRC; i++) begin
        if (sel == SW'(i)) begin
          if (wr_mode && mode_ok) begin
            trig[i] <= bus_wdata[5:4];
            prio[i] <= bus_wdata[PW-1:0];
          end
          if (wr_vec && !wp) vec[i] <= bus_wdata[VEC_W-1:0];
          if (wr_en) en[i] <= 1'b1;
          if (wr_dis) en[i] <= 1'b0;
        end
        if (trig[i][0] && (trig[i][1] ? (s3[i] && !s2[i]) : (s2[i] && !s3[i])))
          epend[i] <= 1'b1;
        else if ((ack && best_i == SW'(i)) || (wr_clr && sel == SW'(i)))
          epend[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      for (int j = 0; j < DEPTH; j++) stk[j] <= '0;
    end else if (ack && sp < SPW'(DEPTH)) begin
      stk[PW'(sp)] <= best_p;
      sp <= sp + 1'b1;
    end else if (wr_eoi && sp != '0) begin
      sp <= sp - 1'b1;
    end
  end

  a_r11_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));
  a_r7_ack_pushes: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> sp == $past(sp) + 1'b1);
  a_r8_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eoi && sp != '0) |=> sp == $past(sp) - 1'b1);
  a_r8_eoi_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_eoi && sp == '0) |=> sp == '0);
  a_r9_locked_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && wp) |=> $stable(mode_sel));

  for (genvar j = 1; j < DEPTH; j++) begin : g_order
    a_r11_stack_order: assert property (@(posedge clk) disable iff (!rst_n)
      (sp > SPW'(j)) |-> stk[j] > stk[j-1]);
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_int
    if (!EXT_MASK[g]) begin : g_chk
      a_r3_internal_trig: assert property (@(posedge clk) disable iff (!rst_n)
        trig[g][1] == 1'b0);
    end
  end
endmodule

// File: tb/sim_nested_prio_intc.sv
module sim_nested_prio_intc;
  localparam int N = 12;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] src_in = '0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, rv;
  logic bus_we = 0, bus_re = 0, irq;
  int checks = 0, failures = 0;

  nested_prio_intc #(.NSRC(N), .NPRIO(8), .VEC_W(8), .EXT_MASK(12'h0F0)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq(irq));

  always #2 clk = ~clk;

  function automatic int pr(int i);
    return (i * 5) % 8;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a);
    @(negedge clk); bus_addr = a; bus_re = 1; #1 rv = bus_rdata;
    @(negedge clk); bus_re = 0;
  endtask

  task automatic do_reset();
    src_in = '0; rst_n = 0; wt(3); rst_n = 1; wt(2);
  endtask

  task automatic setup();
    wr(4, 32'hFF);
    for (int i = 0; i < N; i++) begin
      wr(0, i); wr(2, 32'h20 + i); wr(1, pr(i)); wr(6, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 irq", irq, 0);
    rd(3); chk("R1 ack read", rv, 0);
    rd(1); chk("R1 mode", rv, 0);
    rd(2); chk("R1 vec", rv, 0);
    setup();

    for (int i = 0; i < N; i++) begin
      src_in = 1 << i; wt(5);
      chk("R4 level raises irq", irq, 1);
      rd(3); chk("R6 vector", rv, 32'h20 + i);
      wt(3); chk("R7 no self nest", irq, 0);
      wr(5, 32'hDEAD); wt(3); chk("R8 pop restores", irq, 1);
      src_in = '0; wt(5); chk("R4 level drop", irq, 0);
    end

    for (int a = 0; a < N; a++)
      for (int b = a + 1; b < N; b++) begin
        src_in = (1 << a) | (1 << b); wt(5);
        rd(3); chk("R6 pair winner", rv, 32'h20 + ((pr(a) >= pr(b)) ? a : b));
        wr(5, 0); src_in = '0; wt(5);
      end

    wr(0, 3); wr(7, 0); src_in = 1 << 3; wt(5);
    chk("R10 disabled quiet", irq, 0);
    rd(3); chk("R10 spurious", rv, 32'hFF);
    wr(6, 0); wt(4); chk("R10 enable passes", irq, 1);
    wr(2, 32'h77); wr(0, 4); rd(2); chk("R2 other vec", rv, 32'h24);
    wr(0, 3); rd(2); chk("R2 selected vec", rv, 32'h77);
    rd(3); chk("R2 ack uses vec", rv, 32'h77);
    wr(5, 0); src_in = '0;
    wr(0, 12); rd(0); chk("R2 select range", rv, 3);

    do_reset(); setup();
    wr(0, 1); wr(1, 32'h10 | pr(1));
    src_in[1] = 1; wt(2); src_in[1] = 0; wt(5);
    chk("R5 edge latched", irq, 1);
    rd(3); chk("R5 edge vector", rv, 32'h21);
    wr(5, 0); wt(4); chk("R5 ack clears", irq, 0);
    src_in[1] = 1; wt(2); src_in[1] = 0; wt(5);
    chk("R5 edge again", irq, 1);
    wr(8, 0); wt(4); chk("R5 clear cmd", irq, 0);

    src_in[5] = 1; wt(4);
    wr(0, 5); wr(1, 32'h30 | pr(5)); rd(1);
    chk("R3 ext falling mode", rv, 32'h30 | pr(5));
    wt(4); chk("R3 no edge yet", irq, 0);
    src_in[5] = 0; wt(5); chk("R3 falling edge", irq, 1);
    rd(3); chk("R3 falling vector", rv, 32'h25);
    wr(5, 0); wt(4); chk("R3 falling cleared", irq, 0);
    src_in[6] = 1; wt(4);
    wr(0, 6); wr(1, 32'h20 | pr(6)); wt(4);
    chk("R4 low level idle", irq, 0);
    src_in[6] = 0; wt(5); chk("R4 low level active", irq, 1);
    src_in[6] = 1; wt(5); chk("R4 low level released", irq, 0);
    wr(0, 2); wr(1, 32'h31); rd(1); chk("R3 internal reject falling", rv, pr(2));
    wr(1, 32'h21); rd(1); chk("R3 internal reject low", rv, pr(2));

    do_reset(); setup();
    wr(5, 0);
    for (int k = 0; k < 8; k++) begin wr(0, k); wr(1, k); end
    for (int k = 0; k < 8; k++) begin
      src_in[k] = 1; wt(5);
      chk("R7 higher interrupts", irq, 1);
      rd(3); chk("R7 nest vector", rv, 32'h20 + k);
      wt(3); chk("R7 masked by top", irq, 0);
    end
    rd(3); chk("R11 full stack spurious", rv, 32'hFF);
    wr(5, 32'h1234); wt(3); chk("R8 pop unmasks", irq, 1);
    for (int k = 0; k < 8; k++) wr(5, 32'hFFFF_FFFF);
    rd(3); chk("R8 empty after pops", rv, 32'h27);
    wr(5, 0); src_in = '0; wt(4);

    wr(9, 32'h50524F01); rd(9); chk("R9 lock on", rv, 1);
    wr(0, 4); wr(2, 32'h99); rd(2); chk("R9 vec locked", rv, 32'h24);
    wr(1, 32'h07); rd(1); chk("R9 mode locked", rv, pr(4));
    wr(9, 32'h12345600); rd(9); chk("R9 wrong key", rv, 1);
    wr(9, 32'h50524F00); wr(2, 32'h99); rd(2); chk("R9 unlocked", rv, 32'h99);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule